// File: doc/BRIEF.md
# Bidirectional Address Window Translator

This block maps a 32-bit address between a physical address map and a virtual address map. Two windows are recognised: a video memory window and a main memory window. Each window is one contiguous range that moves as a whole by a fixed offset. A direction input picks the mapping. When it is 0 the input is a physical address and the output is virtual. When it is 1 the input is virtual and the output is physical.

A request is one address with a valid strobe. The result appears one clock later, together with a hit flag and an error flag. If an address falls in no window, it comes out unchanged and the error flag is raised. The access is not blocked. The main memory physical base and size are parameters. The video window is at a fixed place: physical 0x18000000, size 0x00600000, virtual 0x1F000000. The main window's virtual base is 0x08000000.

Top module: `addr_xlate`

## Requirements
- R1: After reset, outValid, outHit and outErr are 0.
- R2: outValid equals inValid delayed by one clock. outAddr, outHit and outErr hold the result for the request sampled at that same edge.
- R3: With inDir=0 (physical to virtual), an address in [0x18000000, 0x18600000) yields addr - 0x18000000 + 0x1F000000 with hit.
- R4: With inDir=0, an address in [MAIN_PBASE, MAIN_PBASE+MAIN_SIZE) that is not in the video window yields addr - MAIN_PBASE + 0x08000000 with hit. The video window is tested first.
- R5: With inDir=1 (virtual to physical), an address in [0x1F000000, 0x1F600000) yields addr - 0x07000000 with hit. The video window is tested first.
- R6: With inDir=1, an address in [0x08000000, 0x08000000+MAIN_SIZE) that is not in the video window yields addr - 0x08000000 + MAIN_PBASE with hit.
- R7: An address that matches no window for the selected direction is returned unmodified, with outErr=1 and outHit=0.
- R8: Window bounds include the base and exclude base+size. For example, base-1 and base+size miss, while base and base+size-1 hit.
- R9: Whenever outValid is 1, exactly one of outHit and outErr is 1. When outValid is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inDir | input | 1 | 0: physical to virtual, 1: virtual to physical |
| inAddr | input | 32 | Address to translate |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outAddr | output | 32 | Translated or passed-through address |
| outHit | output | 1 | Address matched a window |
| outErr | output | 1 | Address matched no window |

## Verification
Directed vectors sit on each window's first byte, its last byte, and the bytes just outside it, in both directions. These catch an off-by-one or a wrongly inclusive bound on either edge. Addresses valid in one map are also sent with the other direction selected. This shows that the direction select switches which windows are used and does not only change the offset. Random addresses are biased into the windows, with random valid gaps. They check the translated value, the flag exclusivity and the one-cycle valid alignment against a bench model.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  localparam int AW = 32;
  typedef enum logic [1:0] {WIN_NONE = 2'd0, WIN_VID = 2'd1, WIN_MAIN = 2'd2} win_e;
  typedef struct packed {
    logic load;
    logic dir;
    win_e win;
  } xlate_ctl_t;
endpackage

// File: rtl/addr_xlate_ctrl.sv
module addr_xlate_ctrl
  import addr_xlate_pkg::*;
#(
  parameter logic [31:0] VID_PBASE  = 32'h1800_0000,
  parameter logic [31:0] VID_SIZE   = 32'h0060_0000,
  parameter logic [31:0] VID_VBASE  = 32'h1F00_0000,
  parameter logic [31:0] MAIN_PBASE = 32'h2000_0000,
  parameter logic [31:0] MAIN_SIZE  = 32'h0800_0000,
  parameter logic [31:0] MAIN_VBASE = 32'h0800_0000
) (
  input  logic          inValid,
  input  logic          inDir,
  input  logic [AW-1:0] inAddr,
  output xlate_ctl_t    ctl
);
  localparam int NWIN = 2;
  logic [AW-1:0] winBase [NWIN];
  logic [NWIN-1:0] winMatch;

  always_comb begin
    // Entry 0 is the video window, entry 1 the main window.
    winBase[0] = inDir ? VID_VBASE : VID_PBASE;
    winBase[1] = inDir ? MAIN_VBASE : MAIN_PBASE;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [AW-1:0] SZ = (g == 0) ? VID_SIZE : MAIN_SIZE;
    logic [AW:0] top;
    assign top = {1'b0, winBase[g]} + {1'b0, SZ};
    assign winMatch[g] = (inAddr >= winBase[g]) && ({1'b0, inAddr} < top);
  end

  always_comb begin
    ctl.load = inValid;
    ctl.dir  = inDir;
    if (winMatch[0])      ctl.win = WIN_VID;
    else if (winMatch[1]) ctl.win = WIN_MAIN;
    else                  ctl.win = WIN_NONE;
  end
endmodule

// File: rtl/addr_xlate_dp.sv
module addr_xlate_dp
  import addr_xlate_pkg::*;
#(
  parameter logic [31:0] VID_PBASE  = 32'h1800_0000,
  parameter logic [31:0] VID_VBASE  = 32'h1F00_0000,
  parameter logic [31:0] MAIN_PBASE = 32'h2000_0000,
  parameter logic [31:0] MAIN_VBASE = 32'h0800_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  xlate_ctl_t    ctl,
  input  logic [AW-1:0] inAddr,
  output logic          outValid,
  output logic [AW-1:0] outAddr,
  output logic          outHit,
  output logic          outErr
);
  localparam logic [AW-1:0] VID_P2V  = VID_VBASE - VID_PBASE;
  localparam logic [AW-1:0] MAIN_P2V = MAIN_VBASE - MAIN_PBASE;

  logic [AW-1:0] offset;
  logic [AW-1:0] nextAddr;

  always_comb begin
    unique case (ctl.win)
      WIN_VID:  offset = VID_P2V;
      WIN_MAIN: offset = MAIN_P2V;
      default:  offset = '0;
    endcase
    nextAddr = ctl.dir ? (inAddr - offset) : (inAddr + offset);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outHit   <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= ctl.load;
      outHit   <= ctl.load && (ctl.win != WIN_NONE);
      outErr   <= ctl.load && (ctl.win == WIN_NONE);
      if (ctl.load) outAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import addr_xlate_pkg::*;
#(
  parameter logic [31:0] MAIN_PBASE = 32'h2000_0000,
  parameter logic [31:0] MAIN_SIZE  = 32'h0800_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inDir,
  input  logic [31:0] inAddr,
  output logic        outValid,
  output logic [31:0] outAddr,
  output logic        outHit,
  output logic        outErr
);
  localparam logic [31:0] VID_PBASE  = 32'h1800_0000;
  localparam logic [31:0] VID_SIZE   = 32'h0060_0000;
  localparam logic [31:0] VID_VBASE  = 32'h1F00_0000;
  localparam logic [31:0] MAIN_VBASE = 32'h0800_0000;

  xlate_ctl_t ctl;

  addr_xlate_ctrl #(
    .VID_PBASE(VID_PBASE), .VID_SIZE(VID_SIZE), .VID_VBASE(VID_VBASE),
    .MAIN_PBASE(MAIN_PBASE), .MAIN_SIZE(MAIN_SIZE), .MAIN_VBASE(MAIN_VBASE)
  ) u_ctrl (
    .inValid(inValid), .inDir(inDir), .inAddr(inAddr), .ctl(ctl)
  );

  addr_xlate_dp #(
    .VID_PBASE(VID_PBASE), .VID_VBASE(VID_VBASE),
    .MAIN_PBASE(MAIN_PBASE), .MAIN_VBASE(MAIN_VBASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inAddr(inAddr),
    .outValid(outValid), .outAddr(outAddr), .outHit(outHit), .outErr(outErr)
  );
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inDir,
  input logic [31:0] inAddr,
  input logic        outValid,
  input logic [31:0] outAddr,
  input logic        outHit,
  input logic        outErr
);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  idle_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $countones({outHit, outErr}) == 1);
  // R9
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outHit && !outErr);
  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outErr -> outAddr == $past(inAddr)));
  // R5
  vid_v2p_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inDir && inAddr >= 32'h1F00_0000 && inAddr < 32'h1F60_0000)
      |=> outHit && outAddr == $past(inAddr) - 32'h0700_0000);
endmodule

bind addr_xlate addr_xlate_chk u_chk (.*);

// File: tb/addr_xlate_tb.sv
module addr_xlate_tb;
  localparam logic [31:0] MPB = 32'h2000_0000;
  localparam logic [31:0] MSZ = 32'h0800_0000;
  localparam logic [31:0] MVB = 32'h0800_0000;

  logic clk = 0, rstN = 0, inValid = 0, inDir = 0;
  logic [31:0] inAddr = 0;
  logic outValid, outHit, outErr;
  logic [31:0] outAddr;
  int nChk = 0, nBad = 0;

  always #4 clk = ~clk;

  addr_xlate #(.MAIN_PBASE(MPB), .MAIN_SIZE(MSZ)) u_dut (.*);

  function automatic logic [32:0] model(input logic d, input logic [31:0] a);
    // returns {hit, addr}
    if (!d) begin
      if (a >= 32'h1800_0000 && a < 32'h1860_0000) return {1'b1, a - 32'h1800_0000 + 32'h1F00_0000};
      if (a >= MPB && {1'b0, a} < {1'b0, MPB} + {1'b0, MSZ}) return {1'b1, a - MPB + MVB};
    end else begin
      if (a >= 32'h1F00_0000 && a < 32'h1F60_0000) return {1'b1, a - 32'h0700_0000};
      if (a >= MVB && {1'b0, a} < {1'b0, MVB} + {1'b0, MSZ}) return {1'b1, a - MVB + MPB};
    end
    return {1'b0, a};
  endfunction

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic d, input logic [31:0] a);
    logic [32:0] m;
    m = model(d, a);
    inValid = 1; inDir = d; inAddr = a;
    @(posedge clk); #1;
    inValid = 0;
    check(req, {outValid, outHit, outErr, outAddr}, {1'b1, m[32], ~m[32], m[31:0]});
  endtask

  initial begin
    #100000000;
    nBad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {outValid, outHit, outErr, 32'h0}, 35'h0);
    rstN = 1;
    @(posedge clk); #1;
    check("R1", {outValid, outHit, outErr, 32'h0}, 35'h0);
    // R3 / R8
    apply("R3", 0, 32'h1800_0000);
    apply("R3", 0, 32'h185F_FFFF);
    apply("R8", 0, 32'h17FF_FFFF);
    apply("R8", 0, 32'h1860_0000);
    // R4 / R8
    apply("R4", 0, MPB);
    apply("R4", 0, MPB + MSZ - 1);
    apply("R8", 0, MPB - 1);
    apply("R8", 0, MPB + MSZ);
    // R5 / R8
    apply("R5", 1, 32'h1F00_0000);
    apply("R5", 1, 32'h1F5F_FFFF);
    apply("R8", 1, 32'h1F60_0000);
    apply("R8", 1, 32'h1EFF_FFFF);
    // R6 / R8
    apply("R6", 1, MVB);
    apply("R6", 1, MVB + MSZ - 1);
    apply("R8", 1, MVB - 1);
    apply("R8", 1, MVB + MSZ);
    // R7: direction swap
    apply("R7", 1, 32'h1800_0010);
    apply("R7", 0, 32'h1F00_0010);
    apply("R7", 0, 32'hFFFF_FFFF);
    // R2: a gap leaves valid low
    @(posedge clk); #1;
    check("R2", {outValid, outHit, outErr, 32'h0}, 35'h0);
    // R9 / random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic d;
      d = 1'($urandom());
      case ($urandom_range(3))
        0: a = (d ? 32'h1F00_0000 : 32'h1800_0000) + $urandom_range(32'h0060_0000) - 32'd8;
        1: a = (d ? MVB : MPB) + $urandom_range(MSZ) - 32'd8;
        default: a = $urandom();
      endcase
      apply("R9", d, a);
      if ($urandom_range(3) == 0) begin
        @(posedge clk); #1;
        check("R2", {outValid, outHit, outErr, 32'h0}, 35'h0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule